// File: doc/BRIEF.md
# Dual-Channel Memory/IO Transfer Engine

This block moves data between two address spaces on behalf of a processor. It has two independent channels. Each channel holds a 16-bit control word, a source pointer, a destination pointer and a transfer counter. Each transfer reads one item from the source and then writes the same item to the destination, using a request/acknowledge bus port. Bus timing and wait states belong to whoever answers that port.

Software programs a channel through a small register write port and can read the registers back. The control word sets these things for each channel:
- the pacing: free-running, or gated by a request line;
- where the request comes from: an external pin or an internal requester;
- whether the channel stops at terminal count, and whether it interrupts there;
- the pointer stepping, separately for each side;
- memory or I/O space, separately for each side;
- byte or word size;
- priority against the other channel.

A channel runs while its start bit is set. When terminal count stops a channel, the block clears the start bit itself.

Top module: `dma2ch_ctrl`

## Requirements
- R1: After reset, bus_req and both irq bits are low, and every channel register reads zero.
- R2: The control word bit map is as follows. Bits 15, 14 and 13 are destination memory, destination decrement and destination increment. Bits 12, 11 and 10 are the same three for the source. Bit 9 is stop-on-count, bit 8 is interrupt enable, bits 7:6 are the pacing field, bit 5 is priority and bit 4 selects the internal request. Bit 2 is change-start, bit 1 is start and bit 0 selects word size. Bits 3 and 2 always read back as zero. Every other bit reads back as written.
- R3: A control write changes the start bit only when the same write has bit 2 set. Without bit 2, the start bit keeps its previous value.
- R4: A transfer is a read cycle at the source pointer (bus_write=0), then a write cycle at the destination pointer (bus_write=1) that carries the data just read. For each side, bus_io is 1 when that side's memory bit is 0. bus_word follows bit 0.
- R5: After each transfer, each pointer steps by 2 for word size or 1 for byte size. The source pointer goes up when only its increment bit is set and down when only its decrement bit is set. It holds when both or neither are set. The destination pointer follows the same rules with its own bits.
- R6: The counter decrements once per transfer. With stop-on-count set, the channel stops when the counter reaches zero and its start bit reads 0.
- R7: With pacing 00 (free-running), the channel transfers without any request and stops at count zero even when stop-on-count is clear.
- R8: With pacing 01 or 10 and stop-on-count clear, the counter wraps past zero and the channel keeps transferring while it is requested.
- R9: At terminal count, irq[ch] pulses for exactly one cycle, and only if both interrupt enable and stop-on-count are set.
- R10: With pacing 01 or 10, a transfer starts only while the selected request is high. Bit 4 set selects drq_int[ch], and drq_ext[ch] is then ignored. Bit 4 clear selects drq_ext[ch].
- R11: A channel that is configured wrongly never transfers, even while started. This covers pacing 11, and bit 4 set with any pacing other than 01.
- R12: When both channels request and their priorities differ, the channel with bit 5 set is served first.
- R13: When both channels request with equal priority, grants alternate between them.
- R14: Arbitration takes place only between complete transfers: a read cycle is always followed by the write cycle of the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel addressed by the write |
| reg_sel | input | 2 | Write target: 0 control, 1 source pointer, 2 destination pointer, 3 counter |
| reg_wdata | input | ADDR_W | Write data |
| rd_ch | input | 1 | Channel addressed by the read |
| rd_sel | input | 2 | Read target, same encoding as reg_sel |
| rd_data | output | ADDR_W | Read data, zero-extended |
| drq_ext | input | 2 | External request, one per channel |
| drq_int | input | 2 | Internal request, one per channel |
| bus_req | output | 1 | Bus cycle requested |
| bus_write | output | 1 | 1 for the write cycle, 0 for the read cycle |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_io | output | 1 | 1 for I/O space, 0 for memory |
| bus_word | output | 1 | 1 for word size, 0 for byte |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Bus cycle completes on this edge |
| bus_rdata | input | DATA_W | Read data, taken on the acknowledge edge |
| irq | output | 2 | Terminal-count interrupt pulse, one per channel |

## Verification
The transfer path runs with word steps upward on both sides, and separately with byte steps downward on the source and a held destination. This tells the step size apart from the step direction and from the hold case. Terminal count is exercised in free-running mode with stop-on-count clear, and in request-paced mode with it both set and clear. Together these show that pacing changes how the counter ends a run and when an interrupt fires. The two channels request at the same edge with unequal priorities and then with equal ones. The resulting grant order tells fixed priority apart from alternation.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
   localparam int NUM_CH = 2;
   localparam int CTRL_W = 16;

   // control word field positions
   localparam int B_DMEM = 15;
   localparam int B_DDEC = 14;
   localparam int B_DINC = 13;
   localparam int B_SMEM = 12;
   localparam int B_SDEC = 11;
   localparam int B_SINC = 10;
   localparam int B_TC   = 9;
   localparam int B_INT  = 8;
   localparam int B_SYN1 = 7;
   localparam int B_SYN0 = 6;
   localparam int B_PRI  = 5;
   localparam int B_IREQ = 4;
   localparam int B_CHG  = 2;
   localparam int B_ST   = 1;
   localparam int B_WORD = 0;

   typedef enum logic [1:0] {
      PACE_FREE = 2'b00,
      PACE_SRC  = 2'b01,
      PACE_DST  = 2'b10,
      PACE_RSVD = 2'b11
   } pace_e;

   typedef enum logic [1:0] {
      RSEL_CTRL = 2'd0,
      RSEL_SRC  = 2'd1,
      RSEL_DST  = 2'd2,
      RSEL_CNT  = 2'd3
   } rsel_e;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_READ  = 2'd1,
      XF_WRITE = 2'd2
   } xf_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma2ch_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [ADDR_W-1:0]     wr_data,
   input  logic                  xfer_done,
   input  logic                  drq_ext,
   input  logic                  drq_int,
   output logic [CTRL_W-1:0]     ctrl_q,
   output logic [ADDR_W-1:0]     src_q,
   output logic [ADDR_W-1:0]     dst_q,
   output logic [CNT_W-1:0]      cnt_q,
   output logic                  want,
   output logic                  tc_irq
);
   pace_e              pace;
   logic               cfg_err;
   logic               req_line;
   logic               stop_en;
   logic [CNT_W-1:0]   cnt_next;
   logic               reach_zero;
   logic [ADDR_W-1:0]  step_amt;
   logic [ADDR_W-1:0]  src_next;
   logic [ADDR_W-1:0]  dst_next;

   function automatic logic [ADDR_W-1:0] step_ptr(
      input logic [ADDR_W-1:0] ptr,
      input logic              up,
      input logic              down,
      input logic [ADDR_W-1:0] amt
   );
      if (up && !down)
         return ptr + amt;
      else if (down && !up)
         return ptr - amt;
      else
         return ptr;
   endfunction

   assign pace       = pace_e'(ctrl_q[B_SYN1:B_SYN0]);
   assign cfg_err    = (pace == PACE_RSVD) || (ctrl_q[B_IREQ] && (pace != PACE_SRC));
   assign req_line   = ctrl_q[B_IREQ] ? drq_int : drq_ext;
   assign stop_en    = ctrl_q[B_TC] || (pace == PACE_FREE);
   assign want       = ctrl_q[B_ST] && !cfg_err && ((pace == PACE_FREE) || req_line);
   assign cnt_next   = cnt_q - CNT_W'(1);
   assign reach_zero = (cnt_next == '0);
   assign step_amt   = ctrl_q[B_WORD] ? ADDR_W'(2) : ADDR_W'(1);
   assign src_next   = step_ptr(src_q, ctrl_q[B_SINC], ctrl_q[B_SDEC], step_amt);
   assign dst_next   = step_ptr(dst_q, ctrl_q[B_DINC], ctrl_q[B_DDEC], step_amt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         tc_irq <= 1'b0;
      end else begin
         tc_irq <= 1'b0;
         if (wr_en) begin
            unique case (rsel_e'(wr_sel))
               RSEL_CTRL: ctrl_q <= {wr_data[15:4], 2'b00,
                                     wr_data[B_CHG] ? wr_data[B_ST] : ctrl_q[B_ST],
                                     wr_data[B_WORD]};
               RSEL_SRC:  src_q  <= wr_data;
               RSEL_DST:  dst_q  <= wr_data;
               RSEL_CNT:  cnt_q  <= wr_data[CNT_W-1:0];
               default:   ;
            endcase
         end
         // completion bookkeeping overrides a same-cycle software write
         if (xfer_done) begin
            src_q <= src_next;
            dst_q <= dst_next;
            cnt_q <= cnt_next;
            if (reach_zero && stop_en) begin
               ctrl_q[B_ST] <= 1'b0;
               tc_irq       <= ctrl_q[B_INT] && ctrl_q[B_TC];
            end
         end
      end
   end
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
   import dma2ch_pkg::*;
#(
   parameter bit RR_FAIR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] want,
   input  logic [NUM_CH-1:0] prio,
   input  logic              take,
   output logic              grant_vld,
   output logic              grant_ch
);
   logic tie_pick;

   generate
      if (RR_FAIR) begin : g_rr
         logic last_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               last_q <= 1'b1;
            else if (take)
               last_q <= grant_ch;
         end
         assign tie_pick = ~last_q;
      end else begin : g_fixed
         assign tie_pick = 1'b0;
      end
   endgenerate

   always_comb begin
      grant_vld = |want;
      if (want[0] && want[1]) begin
         if (prio[0] != prio[1])
            grant_ch = prio[1];
         else
            grant_ch = tie_pick;
      end else begin
         grant_ch = want[1];
      end
   end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma2ch_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_vld,
   input  logic              grant_ch,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              src_io,
   input  logic              dst_io,
   input  logic              word_sz,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              act_ch,
   output logic              take,
   output logic [NUM_CH-1:0] done,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_io,
   output logic              bus_word,
   output logic [DATA_W-1:0] bus_wdata
);
   xf_state_e         state_q;
   logic              act_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         act_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            XF_IDLE: if (grant_vld) begin
               act_q   <= grant_ch;
               state_q <= XF_READ;
            end
            XF_READ: if (bus_ack) begin
               data_q  <= bus_rdata;
               state_q <= XF_WRITE;
            end
            XF_WRITE: if (bus_ack)
               state_q <= XF_IDLE;
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign act_ch    = act_q;
   assign take      = (state_q == XF_IDLE) && grant_vld;
   assign bus_req   = (state_q != XF_IDLE);
   assign bus_write = (state_q == XF_WRITE);
   assign bus_addr  = bus_write ? dst_addr : src_addr;
   assign bus_io    = bus_write ? dst_io : src_io;
   assign bus_word  = word_sz;
   assign bus_wdata = data_q;

   always_comb begin
      done = '0;
      if ((state_q == XF_WRITE) && bus_ack)
         done[act_q] = 1'b1;
   end
endmodule

// File: rtl/dma2ch_ctrl.sv
module dma2ch_ctrl
   import dma2ch_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter bit RR_FAIR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_ch,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              rd_ch,
   input  logic [1:0]        rd_sel,
   output logic [ADDR_W-1:0] rd_data,
   input  logic [1:0]        drq_ext,
   input  logic [1:0]        drq_int,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_io,
   output logic              bus_word,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        irq
);
   generate
      if (ADDR_W < CTRL_W) begin : g_bad_addr
         $error("ADDR_W must be at least the control word width");
      end
      if ((CNT_W < 2) || (CNT_W > ADDR_W)) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and ADDR_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_word;
   logic [NUM_CH-1:0][ADDR_W-1:0] src_ptr;
   logic [NUM_CH-1:0][ADDR_W-1:0] dst_ptr;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt;
   logic [NUM_CH-1:0]             want;
   logic [NUM_CH-1:0]             prio;
   logic [NUM_CH-1:0]             done;
   logic                          grant_vld;
   logic                          grant_ch;
   logic                          take;
   logic                          act_ch;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         dma_chan_regs #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
         ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr && (reg_ch == 1'(c))),
            .wr_sel    (reg_sel),
            .wr_data   (reg_wdata),
            .xfer_done (done[c]),
            .drq_ext   (drq_ext[c]),
            .drq_int   (drq_int[c]),
            .ctrl_q    (ctrl_word[c]),
            .src_q     (src_ptr[c]),
            .dst_q     (dst_ptr[c]),
            .cnt_q     (cnt[c]),
            .want      (want[c]),
            .tc_irq    (irq[c])
         );
         assign prio[c] = ctrl_word[c][B_PRI];
      end
   endgenerate

   dma_arbiter #(
      .RR_FAIR (RR_FAIR)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .want      (want),
      .prio      (prio),
      .take      (take),
      .grant_vld (grant_vld),
      .grant_ch  (grant_ch)
   );

   dma_xfer_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_vld (grant_vld),
      .grant_ch  (grant_ch),
      .src_addr  (src_ptr[act_ch]),
      .dst_addr  (dst_ptr[act_ch]),
      .src_io    (!ctrl_word[act_ch][B_SMEM]),
      .dst_io    (!ctrl_word[act_ch][B_DMEM]),
      .word_sz   (ctrl_word[act_ch][B_WORD]),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .act_ch    (act_ch),
      .take      (take),
      .done      (done),
      .bus_req   (bus_req),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_io    (bus_io),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata)
   );

   always_comb begin
      unique case (rsel_e'(rd_sel))
         RSEL_CTRL: rd_data = ADDR_W'(ctrl_word[rd_ch]);
         RSEL_SRC:  rd_data = src_ptr[rd_ch];
         RSEL_DST:  rd_data = dst_ptr[rd_ch];
         RSEL_CNT:  rd_data = ADDR_W'(cnt[rd_ch]);
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dma2ch_ctrl_chk.sv
module dma2ch_ctrl_chk
   import dma2ch_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_req,
   input logic                          bus_ack,
   input logic                          bus_write,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [1:0]                    irq,
   input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_word
);
   // R14: a completed read is always followed by the write of the same transfer
   a_r14_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && !bus_write) |=> (bus_req && bus_write));

   // R4: a bus cycle holds its address and direction until acknowledged
   a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)));

   genvar i;
   generate
      for (i = 0; i < NUM_CH; i++) begin : g_chk
         // R9: the interrupt is a single-cycle pulse
         a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i]);
         // R9: the interrupt needs both enable bits
         a_r9_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (ctrl_word[i][B_INT] && ctrl_word[i][B_TC]));
         // R6: a terminal-count stop clears the start bit
         a_r6_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> !ctrl_word[i][B_ST]);
      end
   endgenerate
endmodule

bind dma2ch_ctrl dma2ch_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_ack   (bus_ack),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .irq       (irq),
   .ctrl_word (ctrl_word)
);

// File: tb/dma2ch_ctrl_bench.sv
`timescale 1ns/1ps
module dma2ch_ctrl_bench;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam int LOGN = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_ch = 1'b0;
   logic [1:0]    reg_sel = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic          rd_ch = 1'b0;
   logic [1:0]    rd_sel = '0;
   logic [AW-1:0] rd_data;
   logic [1:0]    drq_ext = '0;
   logic [1:0]    drq_int = '0;
   logic          bus_req, bus_write, bus_io, bus_word;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic [1:0]    irq;

   int n_chk = 0;
   int n_fail = 0;

   logic [AW-1:0] lg_addr [LOGN];
   logic          lg_wr   [LOGN];
   logic          lg_io   [LOGN];
   logic          lg_word [LOGN];
   logic [DW-1:0] lg_data [LOGN];
   int            n_log = 0;
   int            irq_cnt [2] = '{0, 0};

   always #5 clk = ~clk;

   dma2ch_ctrl u_dma2ch_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
      .drq_ext(drq_ext), .drq_int(drq_int), .bus_req(bus_req), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_io(bus_io), .bus_word(bus_word), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8] ^ a[7:0]};
   endfunction
   assign bus_rdata = mem_of(bus_addr);

   // bus responder and monitor, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
      end else begin
         if (irq[0]) irq_cnt[0]++;
         if (irq[1]) irq_cnt[1]++;
         if (bus_req && !bus_ack) begin
            if (n_log < LOGN) begin
               lg_addr[n_log] = bus_addr;
               lg_wr[n_log]   = bus_write;
               lg_io[n_log]   = bus_io;
               lg_word[n_log] = bus_word;
               lg_data[n_log] = bus_wdata;
               n_log++;
            end
            bus_ack <= 1'b1;
         end else begin
            bus_ack <= 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ceq(input string req, input longint act, input longint exp);
      chk(act == exp, req, act, exp);
   endtask

   function automatic logic [15:0] mk(input bit dmem, ddec, dinc, smem, sdec, sinc,
                                      tc, ien, input logic [1:0] syn,
                                      input bit p, ireq, chg, st, word);
      return {dmem, ddec, dinc, smem, sdec, sinc, tc, ien, syn, p, ireq, 1'b0, chg, st, word};
   endfunction

   task automatic wr_reg(input bit ch, input logic [1:0] sel, input logic [AW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input bit ch, input logic [1:0] sel, output logic [AW-1:0] v);
      @(negedge clk);
      rd_ch = ch; rd_sel = sel;
      #1 v = rd_data;
   endtask

   task automatic setup(input bit ch, input logic [AW-1:0] s, d, input int n);
      wr_reg(ch, 2'd1, s);
      wr_reg(ch, 2'd2, d);
      wr_reg(ch, 2'd3, AW'(n));
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [AW-1:0] v;
      ceq("R1 bus_req in reset", bus_req, 0);
      ceq("R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      rd_reg(0, 2'd0, v); ceq("R1 ctrl0 after reset", v, 0);
      rd_reg(1, 2'd3, v); ceq("R1 count1 after reset", v, 0);
   endtask

   task automatic t_ctrl_rw;
      logic [AW-1:0] v;
      wr_reg(0, 2'd0, 20'h0FFFF);                  // pacing 11: never transfers
      rd_reg(0, 2'd0, v); ceq("R2 readback reserved zero", v, 16'hFFF3);
      wr_reg(0, 2'd0, 20'h00004);
      rd_reg(0, 2'd0, v); ceq("R2 readback cleared", v, 0);
      wr_reg(0, 2'd0, AW'(mk(0,0,0,0,0,0,0,0,2'b01,0,0,0,1,0)));
      rd_reg(0, 2'd0, v); ceq("R3 start ignored without change bit", v[1], 0);
      wr_reg(0, 2'd0, AW'(mk(0,0,0,0,0,0,0,0,2'b01,0,0,1,1,0)));
      rd_reg(0, 2'd0, v); ceq("R3 start set with change bit", v[1], 1);
      wr_reg(0, 2'd0, AW'(mk(0,0,0,0,0,0,0,0,2'b01,1,0,0,0,0)));
      rd_reg(0, 2'd0, v); ceq("R3 start kept while rewriting", v[1], 1);
      ceq("R3 other field rewritten", v[5], 1);
      wr_reg(0, 2'd0, AW'(mk(0,0,0,0,0,0,0,0,2'b01,0,0,1,0,0)));
      rd_reg(0, 2'd0, v); ceq("R3 start cleared with change bit", v[1], 0);
      ceq("R10 paced channel idle without request", n_log, 0);
   endtask

   task automatic t_free_word;
      logic [AW-1:0] v;
      int b = n_log;
      int i0 = irq_cnt[0];
      setup(0, 20'h01000, 20'h02000, 3);
      // dest mem, dest inc, src io, src inc, TC clear, INT set, free-running, word
      wr_reg(0, 2'd0, AW'(mk(1,0,1,0,0,1,0,1,2'b00,0,0,1,1,1)));
      settle(40);
      ceq("R7 free-run stops at zero", n_log - b, 6);
      for (int k = 0; k < 3; k++) begin
         ceq("R4 read addr", lg_addr[b+2*k], 20'h01000 + 2*k);
         ceq("R14 read then write", {lg_wr[b+2*k], lg_wr[b+2*k+1]}, 2'b01);
         ceq("R4 source io", lg_io[b+2*k], 1);
         ceq("R4 dest mem", lg_io[b+2*k+1], 0);
         ceq("R4 word size", lg_word[b+2*k], 1);
         ceq("R5 word step dest", lg_addr[b+2*k+1], 20'h02000 + 2*k);
         ceq("R4 data copied", lg_data[b+2*k+1], mem_of(20'h01000 + 2*k));
      end
      ceq("R9 no irq without TC", irq_cnt[0] - i0, 0);
      rd_reg(0, 2'd0, v); ceq("R7 start cleared", v[1], 0);
      rd_reg(0, 2'd3, v); ceq("R6 count at zero", v, 0);
      rd_reg(0, 2'd1, v); ceq("R5 source pointer advanced", v, 20'h01006);
   endtask

   task automatic t_dec_hold;
      logic [AW-1:0] v;
      int b = n_log;
      int i0 = irq_cnt[0];
      int i1 = irq_cnt[1];
      setup(1, 20'h03010, 20'h04000, 2);
      // dest inc+dec (hold), src dec, TC and INT set, free-running, byte
      wr_reg(1, 2'd0, AW'(mk(1,1,1,1,1,0,1,1,2'b00,0,0,1,1,0)));
      settle(30);
      ceq("R6 two transfers", n_log - b, 4);
      ceq("R5 byte dec first", lg_addr[b], 20'h03010);
      ceq("R5 byte dec second", lg_addr[b+2], 20'h0300F);
      ceq("R5 dest hold first", lg_addr[b+1], 20'h04000);
      ceq("R5 dest hold second", lg_addr[b+3], 20'h04000);
      ceq("R4 byte size", lg_word[b], 0);
      ceq("R9 one irq pulse ch1", irq_cnt[1] - i1, 1);
      ceq("R9 no irq ch0", irq_cnt[0] - i0, 0);
      rd_reg(1, 2'd0, v); ceq("R6 start cleared", v[1], 0);
   endtask

   task automatic t_sync_tc;
      logic [AW-1:0] v;
      int b = n_log;
      int i0 = irq_cnt[0];
      setup(0, 20'h05000, 20'h06000, 2);
      wr_reg(0, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b01,0,0,1,1,0)));
      settle(20);
      ceq("R10 no transfer without external request", n_log - b, 0);
      drq_ext[0] = 1'b1;
      settle(40);
      ceq("R6 paced stop at count", n_log - b, 4);
      ceq("R9 no irq with INT clear", irq_cnt[0] - i0, 0);
      rd_reg(0, 2'd0, v); ceq("R6 start cleared paced", v[1], 0);
      drq_ext[0] = 1'b0;
   endtask

   task automatic t_no_tc;
      logic [AW-1:0] v;
      int b = n_log;
      setup(0, 20'h07000, 20'h08000, 2);
      wr_reg(0, 2'd0, AW'(mk(1,0,0,1,0,0,0,0,2'b10,0,0,1,1,0)));
      drq_ext[0] = 1'b1;
      settle(60);
      drq_ext[0] = 1'b0;
      settle(20);
      chk((n_log - b) > 4, "R8 runs past zero", n_log - b, 6);
      rd_reg(0, 2'd0, v); ceq("R8 start still set", v[1], 1);
      wr_reg(0, 2'd0, AW'(mk(1,0,0,1,0,0,0,0,2'b10,0,0,1,0,0)));
   endtask

   task automatic t_int_req;
      int b = n_log;
      int i1 = irq_cnt[1];
      setup(1, 20'h09000, 20'h0A000, 2);
      drq_ext[1] = 1'b1;
      wr_reg(1, 2'd0, AW'(mk(1,0,1,1,0,1,1,1,2'b01,0,1,1,1,0)));
      settle(30);
      ceq("R10 external ignored with internal select", n_log - b, 0);
      drq_int[1] = 1'b1;
      settle(30);
      ceq("R10 internal request served", n_log - b, 4);
      ceq("R9 irq on paced terminal count", irq_cnt[1] - i1, 1);
      drq_int[1] = 1'b0;
      drq_ext[1] = 1'b0;
   endtask

   task automatic t_cfg_err;
      logic [AW-1:0] v;
      int b = n_log;
      setup(0, 20'h0B000, 20'h0C000, 2);
      wr_reg(0, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b11,0,0,1,1,0)));
      drq_ext[0] = 1'b1;
      settle(30);
      ceq("R11 pacing 11 never transfers", n_log - b, 0);
      rd_reg(0, 2'd0, v); ceq("R11 start still set", v[1], 1);
      drq_int[0] = 1'b1;
      wr_reg(0, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b10,0,1,1,1,0)));
      settle(30);
      ceq("R11 internal with dest pacing never transfers", n_log - b, 0);
      wr_reg(0, 2'd0, 20'h00004);
      drq_ext[0] = 1'b0;
      drq_int[0] = 1'b0;
   endtask

   task automatic t_prio;
      int b = n_log;
      setup(0, 20'h00100, 20'h00500, 2);
      setup(1, 20'h00200, 20'h00600, 2);
      wr_reg(0, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b01,0,0,1,1,0)));
      wr_reg(1, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b01,1,0,1,1,0)));
      @(negedge clk);
      drq_ext = 2'b11;
      settle(50);
      drq_ext = 2'b00;
      ceq("R12 transfer total", n_log - b, 8);
      ceq("R12 high first", lg_addr[b], 20'h00200);
      ceq("R12 high second", lg_addr[b+2], 20'h00201);
      ceq("R12 low third", lg_addr[b+4], 20'h00100);
      ceq("R14 pair kept together", lg_addr[b+5], 20'h00500);
   endtask

   task automatic t_rr;
      int b = n_log;
      setup(0, 20'h00100, 20'h00500, 2);
      setup(1, 20'h00200, 20'h00600, 2);
      wr_reg(0, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b01,1,0,1,1,0)));
      wr_reg(1, 2'd0, AW'(mk(1,0,1,1,0,1,1,0,2'b01,1,0,1,1,0)));
      @(negedge clk);
      drq_ext = 2'b11;
      settle(50);
      drq_ext = 2'b00;
      ceq("R13 transfer total", n_log - b, 8);
      for (int k = 0; k < 3; k++)
         chk(lg_addr[b+2*k][9:8] != lg_addr[b+2*k+2][9:8], "R13 alternation",
             lg_addr[b+2*k+2], lg_addr[b+2*k]);
      for (int k = 0; k < 4; k++)
         ceq("R14 write follows own read", lg_addr[b+2*k+1][10:8],
             lg_addr[b+2*k][9:8] + 3'd4);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      settle(4);
      t_reset();
      t_ctrl_rw();
      t_free_word();
      t_dec_hold();
      t_sync_tc();
      t_no_tc();
      t_int_req();
      t_cfg_err();
      t_prio();
      t_rr();
      settle(5);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule